// File: doc/BRIEF.md
# Asynchronous serial transmitter with one-character holding stage

This block serialises 8-bit characters onto an asynchronous line. A character written through a strobe goes into a one-deep holding stage. At the first bit-rate tick that finds the line free, it moves into a shift stage and is sent. The bit rate comes in as a clock enable (`bit_tick`). It is counted either sixteen ticks per bit or one tick per bit, chosen by `mode_1x`. Enable and disable commands are one-cycle pulses.

Two status flags tell the host what it may do. `tx_rdy` means a write will be accepted. `tx_emt` means the transmitter is enabled with nothing queued and nothing on the line. The timing around disable is exact. A character that has not been under way long enough when disable arrives is thrown away, and the line snaps back to idle. A character past that point completes its frame, and the line then stays idle.

Top module: `uart_txh_top`

## Requirements
- R1: After reset the transmitter is disabled, `txd` is 1, and both `tx_rdy` and `tx_emt` are 0.
- R2: An `en_cmd` pulse with no `dis_cmd` in the same cycle enables the transmitter from the next edge. An idle, empty transmitter then shows `tx_rdy`=1 and `tx_emt`=1 in the following cycle.
- R3: A frame is one start bit (0), then 8 data bits LSB first, then one stop bit (1). Each bit lasts 16 `bit_tick` pulses when `mode_1x`=0, or 1 pulse when `mode_1x`=1. The line idles at 1.
- R4: A write strobe in a cycle where `tx_rdy` is 0 is ignored. Its data is never sent, and the flags are unchanged by it.
- R5: The holding stage empties into the shift stage at the first tick of the start bit. `tx_rdy` stays 0 for the whole start bit. It returns to 1 on the edge where the line leaves the start bit, provided the transmitter is still enabled.
- R6: `tx_emt` is 1 exactly when the transmitter is enabled, the holding stage is empty and no frame is on the line.
- R7: In 16x mode, a disable issued while a character still waits in the holding stage, or while its start bit has run fewer than 3 ticks, discards that character. The line is 1 from the next edge.
- R8: In 1x mode, a disable issued at any point up to the end of the start bit discards the character. The line is 1 from the next edge.
- R9: A disable issued after the drop window lets the frame on the line finish, discards any character waiting in the holding stage, and leaves the line idle.
- R10: A character that is waiting when a stop bit ends starts its start bit on that same tick, with no idle gap.
- R11: A `dis_cmd` wins over an `en_cmd` in the same cycle. A character written in the same cycle as a disable is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | Bit-rate clock enable |
| mode_1x | input | 1 | 1: one tick per bit; 0: sixteen ticks per bit |
| en_cmd | input | 1 | Enable command pulse |
| dis_cmd | input | 1 | Disable command pulse |
| wr_stb | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line output |
| tx_rdy | output | 1 | Holding stage can accept a write |
| tx_emt | output | 1 | Enabled, nothing queued and line idle |

## Verification
The bench sweeps the delay between a write and a disable across the drop window in both rate modes. A design with the window off by one tick would either emit a stray start bit or truncate a frame that should have completed. Back-to-back characters and writes while not ready expose a design that leaves an idle gap between frames or overwrites the queued character. Simultaneous enable/disable and write/disable pulses catch a wrong priority. The bench also checks that `tx_rdy` stays low for the whole start bit; a design that raised it at the moment of transfer would fail there.

// File: rtl/uart_txh_pkg.sv
package uart_txh_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/uart_txh_hold.sv
module uart_txh_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          take,
  input  logic          clear,
  output logic          full,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst)        full <= 1'b0;
    else if (clear) full <= 1'b0;
    else if (load)  full <= 1'b1;
    else if (take)  full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) data <= load_data;
  end

  // R4
  load_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !full);

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> !full);
endmodule

// File: rtl/uart_txh_shift.sv
module uart_txh_shift
  import uart_txh_pkg::*;
#(
  parameter int DW   = 8,
  parameter int OVS  = 16,
  parameter int DROP = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          mode_1x,
  input  logic          go_ok,
  input  logic          dis,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  output logic          take,
  output logic          txd,
  output tx_state_e     state
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BIT_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_DROP = SUB_W'(DROP);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DW - 1);

  logic [SUB_W-1:0] sub;
  logic [BIT_W-1:0] bit_idx;
  logic [DW-1:0]    shreg;
  logic             bit_end;
  logic             abort;

  assign bit_end = mode_1x || (sub == SUB_LAST);
  assign abort   = dis && (state == TX_START) && (mode_1x || (sub < SUB_DROP));
  assign take    = bit_tick && go_ok && hold_full &&
                   ((state == TX_IDLE) || ((state == TX_STOP) && bit_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      sub     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      txd     <= 1'b1;
    end else if (abort) begin
      state <= TX_IDLE;
      sub   <= '0;
      txd   <= 1'b1;
    end else if (bit_tick) begin
      unique case (state)
        TX_IDLE: begin
          if (take) begin
            state <= TX_START;
            sub   <= '0;
            shreg <= hold_data;
            txd   <= 1'b0;
          end
        end
        TX_START: begin
          if (bit_end) begin
            state   <= TX_DATA;
            sub     <= '0;
            bit_idx <= '0;
            txd     <= shreg[0];
            shreg   <= shreg >> 1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            sub <= '0;
            if (bit_idx == BIT_LAST) begin
              state <= TX_STOP;
              txd   <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              txd     <= shreg[0];
              shreg   <= shreg >> 1;
            end
          end else begin
            sub <= sub + 1'b1;
          end
        end
        TX_STOP: begin
          if (bit_end) begin
            sub <= '0;
            if (take) begin
              state <= TX_START;
              shreg <= hold_data;
              txd   <= 1'b0;
            end else begin
              state <= TX_IDLE;
            end
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R7
  drop_goes_idle_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (state == TX_IDLE) && txd);

  // R5
  take_starts_frame_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (state == TX_START) && !txd);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TX_START) |-> !txd);

  // R3
  stop_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TX_STOP) |-> txd);

  // R9
  commit_finish_chk: assert property (@(posedge clk) disable iff (rst)
    (dis && (state == TX_DATA)) |=> (state != TX_IDLE));
endmodule

// File: rtl/uart_txh_top.sv
module uart_txh_top
  import uart_txh_pkg::*;
#(
  parameter int DW   = 8,
  parameter int OVS  = 16,
  parameter int DROP = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          mode_1x,
  input  logic          en_cmd,
  input  logic          dis_cmd,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          txd,
  output logic          tx_rdy,
  output logic          tx_emt
);
  logic          en_q;
  logic          go_ok;
  logic          load;
  logic          take;
  logic          hold_full;
  logic [DW-1:0] hold_data;
  tx_state_e     state;

  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (dis_cmd) en_q <= 1'b0;
    else if (en_cmd)  en_q <= 1'b1;
  end

  assign go_ok = en_q && !dis_cmd;
  assign load  = wr_stb && tx_rdy;

  // Flags are decoded from flops only; no input reaches them combinationally.
  assign tx_rdy = en_q && !hold_full && (state != TX_START);
  assign tx_emt = en_q && !hold_full && (state == TX_IDLE);

  uart_txh_hold #(.DW(DW)) hold_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_data(wr_data),
    .take     (take),
    .clear    (dis_cmd),
    .full     (hold_full),
    .data     (hold_data)
  );

  uart_txh_shift #(.DW(DW), .OVS(OVS), .DROP(DROP)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .mode_1x  (mode_1x),
    .go_ok    (go_ok),
    .dis      (dis_cmd),
    .hold_full(hold_full),
    .hold_data(hold_data),
    .take     (take),
    .txd      (txd),
    .state    (state)
  );

  // R6
  empty_line_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_emt |-> txd);

  // R11
  dis_wins_chk: assert property (@(posedge clk) disable iff (rst)
    dis_cmd |=> !tx_rdy && !tx_emt);

  // R2
  enable_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (en_cmd && !dis_cmd && !hold_full && (state == TX_IDLE) && !bit_tick) |=> tx_emt);
endmodule

// File: tb/uart_txh_top_tb.sv
module uart_txh_top_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, mode_1x = 1'b0;
  logic en_cmd = 1'b0, dis_cmd = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, tx_rdy, tx_emt;

  int checks = 0, errors = 0, cnt = 0, tdiv = 1, cycles = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural model state
  int m_en, m_hfull, m_pos;
  logic [7:0] m_hdata;
  logic [9:0] m_frame;

  always #(CLK_P/2) clk = ~clk;

  uart_txh_top dut_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .mode_1x(mode_1x),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd), .wr_stb(wr_stb), .wr_data(wr_data),
    .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
  );

  function automatic int bit_len();
    return mode_1x ? 1 : 16;
  endfunction
  function automatic logic m_txd();
    return (m_pos < 0) ? 1'b1 : m_frame[m_pos / bit_len()];
  endfunction
  function automatic logic m_rdy();
    return (m_en != 0) && (m_hfull == 0) && !(m_pos >= 0 && m_pos < bit_len());
  endfunction
  function automatic logic m_emt();
    return (m_en != 0) && (m_hfull == 0) && (m_pos < 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_hfull = 0; m_pos = -1; m_hdata = 0; m_frame = '1;
    end else begin
      automatic logic rdy_now = m_rdy();
      automatic int   len = bit_len();
      automatic int   win = mode_1x ? 1 : 3;
      automatic bit   go = (m_en != 0) && !dis_cmd;
      if (dis_cmd && m_pos >= 0 && m_pos < win) begin
        m_pos = -1;
      end else if (bit_tick) begin
        if (m_pos >= 0) begin
          m_pos++;
          if (m_pos == 10 * len) m_pos = -1;
        end
        if (m_pos < 0 && go && m_hfull != 0) begin
          m_pos = 0; m_frame = {1'b1, m_hdata, 1'b0}; m_hfull = 0;
        end
      end
      if (dis_cmd) begin
        m_hfull = 0; m_en = 0;
      end else begin
        if (wr_stb && rdy_now) begin m_hfull = 1; m_hdata = wr_data; end
        if (en_cmd) m_en = 1;
      end
    end
  end

  task automatic check1(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%b exp=%b at cycle %0d", req, what, got, exp, cycles);
    end
  endtask

  task automatic compare();
    check1(cur_req, "txd", txd, m_txd());
    check1(cur_req, "tx_rdy", tx_rdy, m_rdy());
    check1(cur_req, "tx_emt", tx_emt, m_emt());
  endtask

  task automatic cyc(logic e, logic d, logic w, logic [7:0] dat);
    @(negedge clk);
    cycles++;
    if (!rst) compare();
    bit_tick = ((cnt % tdiv) == 0);
    cnt++;
    en_cmd = e; dis_cmd = d; wr_stb = w; wr_data = dat;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00);
  endtask

  task automatic wait_rdy();
    for (int i = 0; i < 2000 && !tx_rdy; i++) cyc(0, 0, 0, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk);
    // R1: reset state
    check1("R1", "txd", txd, 1'b1);
    check1("R1", "tx_rdy", tx_rdy, 1'b0);
    check1("R1", "tx_emt", tx_emt, 1'b0);
    rst = 1'b0;
    idle(4);

    // R4: write while disabled is ignored
    cur_req = "R4";
    cyc(0, 0, 1, 8'h3C);
    idle(3);
    // R2: enable from idle raises both flags
    cur_req = "R2";
    cyc(1, 0, 0, 8'h00);
    idle(2);
    check1("R2", "tx_rdy", tx_rdy, 1'b1);
    check1("R6", "tx_emt", tx_emt, 1'b1);
    idle(40);

    // R3, R5: 16x frame with tick every cycle
    cur_req = "R3 R5";
    cyc(0, 0, 1, 8'hA5);
    idle(6);
    // R4: write while tx_rdy low (start bit) ignored
    cur_req = "R4";
    cyc(0, 0, 1, 8'hFF);
    // R10: queue a character during the data bits
    cur_req = "R10";
    wait_rdy();
    cyc(0, 0, 1, 8'h6E);
    cur_req = "R4";
    cyc(0, 0, 1, 8'h11);
    cur_req = "R10 R6";
    idle(360);

    // R3: slower tick, 16x
    cur_req = "R3";
    tdiv = 2;
    cyc(0, 0, 1, 8'h01);
    idle(340);
    tdiv = 1;

    // R7 / R9: disable at growing delays after a load, 16x
    for (int d = 0; d < 7; d++) begin
      cur_req = (d < 4) ? "R7" : "R9";
      cyc(1, 0, 0, 8'h00);
      wait_rdy();
      cyc(0, 0, 1, 8'h5A ^ 8'(d));
      idle(d);
      cyc(0, 1, 0, 8'h00);
      idle(170);
    end

    // R9: disable mid-frame with a second character waiting
    cur_req = "R9";
    cyc(1, 0, 0, 8'h00);
    wait_rdy();
    cyc(0, 0, 1, 8'hC3);
    wait_rdy();
    cyc(0, 0, 1, 8'h99);
    idle(30);
    cyc(0, 1, 0, 8'h00);
    idle(200);

    // R11: enable and disable together; write with disable
    cur_req = "R11";
    cyc(1, 1, 0, 8'h00);
    idle(3);
    cyc(1, 0, 0, 8'h00);
    wait_rdy();
    cyc(0, 1, 1, 8'h77);
    idle(40);

    // 1x mode, tick every third cycle
    mode_1x = 1'b1;
    tdiv = 3;
    cur_req = "R3 R5";
    cyc(1, 0, 0, 8'h00);
    wait_rdy();
    cyc(0, 0, 1, 8'hB4);
    wait_rdy();
    cur_req = "R10";
    cyc(0, 0, 1, 8'h2D);
    idle(80);
    for (int d = 0; d < 9; d++) begin
      cur_req = (d < 5) ? "R8" : "R9";
      cyc(0, 1, 0, 8'h00);
      idle(4);
      cyc(1, 0, 0, 8'h00);
      wait_rdy();
      idle(d % 3);
      cyc(0, 0, 1, 8'hE1 ^ 8'(d));
      idle(d);
      cyc(0, 1, 0, 8'h00);
      idle(50);
    end
    cur_req = "R6";
    idle(5);
    finish_run();
  end
endmodule